// File: doc/BRIEF.md
# Six-Instruction Integer Core

This block is a single-cycle 32-bit integer processor. Instructions and data live apart: the instructions come from a small word-addressed instruction store, and the only data storage is a register file built from flip-flops. The core supports six operations, encoded in the standard 32-bit integer RISC-V formats. They are add, AND, add-immediate, logical shift right by an immediate, load-upper-immediate and branch-if-not-equal. Together they are enough to build literals and to run a counted loop such as a population count.

A host fills the instruction store through a write port while reset is held. It then releases reset and waits for the halt flag. After that it inspects any register through a combinational debug read port. The program counter is a word index. It steps by one per instruction, or jumps to a branch target computed from a byte offset divided by four.

Top module: `mini_int_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 and every register becomes 0 (synchronous, active-low reset).
- R2: After a non-branch, non-halting instruction, the program counter is the previous value plus one.
- R3: Opcode 0110011 with funct7 0000000 performs rd = rs1 + rs2 for funct3 000 and rd = rs1 AND rs2 for funct3 111. Fields: rd bits 11:7, funct3 bits 14:12, rs1 bits 19:15, rs2 bits 24:20, funct7 bits 31:25.
- R4: Opcode 0010011 with funct3 000 adds the sign-extended 12-bit immediate in bits 31:20 to rs1. Opcode 0110111 writes bits 31:12 followed by twelve zeros into rd.
- R5: Opcode 0010011 with funct3 101 and bits 31:25 zero shifts rs1 right by bits 24:20 and fills with zeros.
- R6: Opcode 1100011 with funct3 001 compares rs1 and rs2. When they differ, the next program counter is the current one plus the signed 13-bit byte offset {b31,b7,b30:25,b11:8,0} divided by four. When they are equal, execution falls through.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: An all-zero word, or any word outside the six formats above, raises `halted`, holds the program counter and blocks register writes.
- R9: The program port writes a word into the store at the next rising edge. The debug port returns the selected register within the same cycle.
- R10: The set-bit counting loop (AND with 1, accumulate, shift right by 1, count to 32) run on 0x00123456 leaves 9 in the accumulator register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | AW (6) | Instruction store word address |
| prog_word | input | 32 | Instruction word to store |
| dbg_sel | input | RAW (5) | Register index for debug read |
| dbg_word | output | 32 | Value of the selected register |
| pc_idx | output | AW (6) | Current program counter (word index) |
| halted | output | 1 | Current instruction is a halt or is not supported |

## Verification
The bench builds the core with its defaults: a 64-word instruction store and 32 registers. With those sizes, a program can branch both backward (the loop) and forward (a skip), every register can be read through the debug port, and every shift amount from 0 to 31 is legal. Random operands and shift amounts drive straight-line arithmetic programs. Random data words drive the full 32-iteration counting loop. Directed programs cover writes to register 0, taken and untaken branches, an unsupported word, and a reset issued after a run.

// File: rtl/mic_pkg.sv
// Shared constants, opcodes and decoded-instruction type for the core.
// Assumes the 32-bit integer base encodings for the six supported operations.
package mic_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_LUI = 7'b0110111;
    localparam logic [6:0] OPC_BRA = 7'b1100011;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_AND   = 2'd1,
        ALU_SRL   = 2'd2,
        ALU_PASSB = 2'd3
    } alu_op_t;

    typedef struct packed {
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [XLEN-1:0] imm;
        alu_op_t         op;
        logic            use_imm;
        logic            wr;
        logic            is_bne;
        logic            stop;
    } dec_t;
endpackage

// File: rtl/instr_store.sv
// Word-addressed instruction store: synchronous write, asynchronous read.
// Assumes it is loaded by the host before the core runs; contents are not reset.
module instr_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] words [DEPTH];

    // Capture a host write on the rising edge.
    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
    end

    // Present the addressed word combinationally for single-cycle fetch.
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/reg_bank.sv
// Flip-flop register file with two operand read ports and one debug read port.
// Index 0 reads as zero and ignores writes; synchronous active-low reset clears all.
module reg_bank #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int RAW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [RAW-1:0]  ra_b,
    output logic [XLEN-1:0] rd_b,
    input  logic [RAW-1:0]  ra_d,
    output logic [XLEN-1:0] rd_d
);
    logic [XLEN-1:0] regs [NREGS];

    // Clear on reset, otherwise store the result unless the target is index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with the zero register forced to zero.
    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    assign rd_d = (ra_d == '0) ? '0 : regs[ra_d];
endmodule

// File: rtl/op_decoder.sv
// Decodes one instruction word into register indices, immediate and controls.
// Assumes only the six supported formats; anything else sets the stop flag.
module op_decoder
    import mic_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [2:0] f3;
    logic [6:0] f7;
    assign f3 = instr[14:12];
    assign f7 = instr[31:25];

    // Field extraction and per-format control selection.
    always_comb begin
        dec.rd      = instr[11:7];
        dec.rs1     = instr[19:15];
        dec.rs2     = instr[24:20];
        dec.imm     = '0;
        dec.op      = ALU_ADD;
        dec.use_imm = 1'b0;
        dec.wr      = 1'b0;
        dec.is_bne  = 1'b0;
        dec.stop    = 1'b1;
        case (instr[6:0])
            OPC_LUI: begin
                dec.imm     = {instr[31:12], 12'b0};
                dec.op      = ALU_PASSB;
                dec.use_imm = 1'b1;
                dec.wr      = 1'b1;
                dec.stop    = 1'b0;
            end
            OPC_IMM: begin
                dec.imm     = {{20{instr[31]}}, instr[31:20]};
                dec.use_imm = 1'b1;
                if (f3 == 3'b000) begin
                    dec.op   = ALU_ADD;
                    dec.wr   = 1'b1;
                    dec.stop = 1'b0;
                end else if (f3 == 3'b101 && f7 == 7'b0) begin
                    dec.op   = ALU_SRL;
                    dec.wr   = 1'b1;
                    dec.stop = 1'b0;
                end
            end
            OPC_REG: begin
                if (f7 == 7'b0 && f3 == 3'b000) begin
                    dec.op   = ALU_ADD;
                    dec.wr   = 1'b1;
                    dec.stop = 1'b0;
                end else if (f7 == 7'b0 && f3 == 3'b111) begin
                    dec.op   = ALU_AND;
                    dec.wr   = 1'b1;
                    dec.stop = 1'b0;
                end
            end
            OPC_BRA: begin
                dec.imm = {{19{instr[31]}}, instr[31], instr[7],
                           instr[30:25], instr[11:8], 1'b0};
                if (f3 == 3'b001) begin
                    dec.is_bne = 1'b1;
                    dec.stop   = 1'b0;
                end
            end
            default: dec.stop = 1'b1;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
// Integer ALU for add, AND, logical right shift and operand pass-through.
// Assumes the shift amount is taken from the low bits of operand b.
module int_alu
    import mic_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_t      op,
    output logic [W-1:0] y
);
    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_SRL: y = a >> b[SHW-1:0];
            default: y = b;
        endcase
    end
endmodule

// File: rtl/mini_int_core.sv
// Single-cycle core: fetch from the instruction store at the program counter,
// decode, execute and write back within one clock. A stop word freezes it.
// Assumes the host loads the program while rst_n is held low.
module mini_int_core
    import mic_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int NREGS      = 32,
    localparam int AW        = $clog2(IMEM_DEPTH),
    localparam int RAW       = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [XLEN-1:0] prog_word,
    input  logic [RAW-1:0]  dbg_sel,
    output logic [XLEN-1:0] dbg_word,
    output logic [AW-1:0]   pc_idx,
    output logic            halted
);
    logic [AW-1:0]   pc;
    logic [XLEN-1:0] instr;
    dec_t            dec;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_y;
    logic            br_taken;
    logic [AW-1:0]   br_target;
    logic            rf_we;

    instr_store #(.XLEN(XLEN), .DEPTH(IMEM_DEPTH), .AW(AW)) u_imem (
        .clk     (clk),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_data (prog_word),
        .rd_addr (pc),
        .rd_data (instr)
    );

    op_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    reg_bank #(.XLEN(XLEN), .NREGS(NREGS), .RAW(RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (dec.rd[RAW-1:0]),
        .wdata (alu_y),
        .ra_a  (dec.rs1[RAW-1:0]),
        .rd_a  (rs1_val),
        .ra_b  (dec.rs2[RAW-1:0]),
        .rd_b  (rs2_val),
        .ra_d  (dbg_sel),
        .rd_d  (dbg_word)
    );

    assign opnd_b = dec.use_imm ? dec.imm : rs2_val;

    int_alu #(.W(XLEN)) u_alu (
        .a  (rs1_val),
        .b  (opnd_b),
        .op (dec.op),
        .y  (alu_y)
    );

    // Control: halt gating, branch decision and word-index target.
    assign halted    = dec.stop;
    assign rf_we     = dec.wr && !dec.stop;
    assign br_taken  = dec.is_bne && !dec.stop && (rs1_val != rs2_val);
    assign br_target = pc + dec.imm[AW+1:2];

    // Program counter: reset to zero, hold on halt, else branch or step.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (!halted)  pc <= br_taken ? br_target : pc + 1'b1;
    end

    assign pc_idx = pc;
endmodule

// File: rtl/mini_int_core_chk.sv
// Property checker for the core's program-counter and register-port behaviour.
module mini_int_core_chk #(
    parameter int AW  = 6,
    parameter int RAW = 5,
    parameter int XW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  pc,
    input logic           halt,
    input logic           br_taken,
    input logic [AW-1:0]  br_target,
    input logic           rf_we,
    input logic [RAW-1:0] dbg_sel,
    input logic [XW-1:0]  dbg_word
);
    // R1
    rst_pc_chk: assert property (@(posedge clk) !rst_n |=> pc == '0);

    // R2
    step_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !br_taken) |=> pc == AW'($past(pc) + 1'b1));

    // R6
    branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> pc == $past(br_target));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(pc));

    // R8
    halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !rf_we);

    // R7
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == '0) |-> dbg_word == '0);
endmodule

bind mini_int_core mini_int_core_chk #(.AW(AW), .RAW(RAW), .XW(mic_pkg::XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc_idx),
    .halt      (halted),
    .br_taken  (br_taken),
    .br_target (br_target),
    .rf_we     (rf_we),
    .dbg_sel   (dbg_sel),
    .dbg_word  (dbg_word)
);

// File: tb/mini_int_core_test.sv
`timescale 1ns/1ps
module mini_int_core_test;
    localparam int AW = 6;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_word = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_word;
    logic [5:0]  pc_idx;
    logic        halted;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] prog [DEPTH];
    int plen = 0;

    mini_int_core uut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_word(prog_word), .dbg_sel(dbg_sel), .dbg_word(dbg_word),
        .pc_idx(pc_idx), .halted(halted)
    );

    always #10 clk = ~clk;

    // Encoders for the supported formats.
    function automatic logic [31:0] e_r(input logic [2:0] f3, input int rd, rs1, rs2);
        return {7'b0, rs2[4:0], rs1[4:0], f3, rd[4:0], 7'b0110011};
    endfunction
    function automatic logic [31:0] e_addi(input int rd, rs1, input logic [11:0] imm);
        return {imm, rs1[4:0], 3'b000, rd[4:0], 7'b0010011};
    endfunction
    function automatic logic [31:0] e_srli(input int rd, rs1, input int sh);
        return {7'b0, sh[4:0], rs1[4:0], 3'b101, rd[4:0], 7'b0010011};
    endfunction
    function automatic logic [31:0] e_lui(input int rd, input logic [19:0] up);
        return {up, rd[4:0], 7'b0110111};
    endfunction
    function automatic logic [31:0] e_bne(input int rs1, rs2, input int off);
        logic [12:0] o;
        o = off[12:0];
        return {o[12], o[10:5], rs2[4:0], rs1[4:0], 3'b001, o[4:1], o[11], 7'b1100011};
    endfunction
    function automatic int popc(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += v[i];
        return n;
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask
    task automatic emit_li(input int rd, input logic [31:0] v);
        logic [31:0] hi;
        hi = v + 32'h800;
        emit(e_lui(rd, hi[31:12]));
        emit(e_addi(rd, rd, v[11:0]));
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input int r, output logic [31:0] v);
        dbg_sel = r[4:0];
        #1;
        v = dbg_word;
    endtask

    // Load the program under reset (R9 write path), leave reset asserted.
    task automatic load_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_addr = a[5:0];
            prog_word = (a < plen) ? prog[a] : 32'h0;
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_prog(input int max_cyc);
        int n = 0;
        load_prog();
        rst_n = 1'b1;
        @(negedge clk);
        while (!halted && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        if (!halted) begin
            vectors++;
            miscompares++;
            $display("FAIL R8 actual=running expected=halted");
        end
    endtask

    task automatic build_popcount(input logic [31:0] d);
        plen = 0;
        emit_li(1, d);
        emit(e_addi(2, 0, 12'd0));
        emit(e_addi(3, 0, 12'd0));
        emit(e_addi(4, 0, 12'd0));
        emit(e_addi(5, 0, 12'd1));
        emit(e_addi(6, 0, 12'd32));
        emit(e_r(3'b111, 4, 1, 5));
        emit(e_r(3'b000, 2, 2, 4));
        emit(e_srli(1, 1, 1));
        emit(e_addi(3, 3, 12'd1));
        emit(e_bne(3, 6, -16));
        emit(32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [31:0] v, a, b, r;
        logic [11:0] im;
        int sh;
        logic [5:0] pc_hold;
        void'($urandom(32'h5eed_1234));

        // R1: reset state with a stop-only program held in reset.
        plen = 0;
        emit(32'h0);
        load_prog();
        chk("R1 pc", {26'b0, pc_idx}, 32'h0);
        for (int i = 1; i < 32; i++) begin
            rd_reg(i, v);
            chk("R1 reg", v, 32'h0);
        end

        // R10: directed counting loop.
        build_popcount(32'h0012_3456);
        run_prog(400);
        rd_reg(2, v); chk("R10 result", v, 32'd9);
        rd_reg(3, v); chk("R10 counter", v, 32'd32);
        rd_reg(1, v); chk("R5 drained", v, 32'h0);
        chk("R8 halt pc", {26'b0, pc_idx}, 32'd12);

        // R10 / R6: random data words through the loop.
        for (int k = 0; k < 6; k++) begin
            a = $urandom();
            if (k == 0) a = 32'hFFFF_FFFF;
            if (k == 1) a = 32'h0;
            build_popcount(a);
            run_prog(400);
            rd_reg(2, v);
            chk("R10 random", v, popc(a));
        end

        // R3 R4 R5 R2: random straight-line arithmetic.
        for (int k = 0; k < 20; k++) begin
            a = $urandom();
            b = $urandom();
            sh = int'($urandom_range(31, 0));
            if (k == 0) sh = 0;
            if (k == 1) sh = 31;
            im = 12'($urandom());
            r = $urandom();
            plen = 0;
            emit_li(1, a);
            emit_li(2, b);
            emit(e_r(3'b000, 3, 1, 2));
            emit(e_r(3'b111, 4, 1, 2));
            emit(e_srli(5, 1, sh));
            emit(e_addi(6, 1, im));
            emit(e_lui(7, r[31:12]));
            emit(32'h0);
            run_prog(50);
            rd_reg(1, v); chk("R4 li", v, a);
            rd_reg(3, v); chk("R3 add", v, a + b);
            rd_reg(4, v); chk("R3 and", v, a & b);
            rd_reg(5, v); chk("R5 srli", v, a >> sh);
            rd_reg(6, v); chk("R4 addi", v, a + {{20{im[11]}}, im});
            rd_reg(7, v); chk("R4 lui", v, {r[31:12], 12'b0});
            chk("R2 sequential pc", {26'b0, pc_idx}, 32'd9);
        end

        // R1: reset after a run clears registers.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_reg(3, v); chk("R1 clear after run", v, 32'h0);
        chk("R1 pc after run", {26'b0, pc_idx}, 32'h0);

        // R7: writes to register 0 ignored.
        plen = 0;
        emit(e_addi(0, 0, 12'd123));
        emit(e_lui(0, 20'hABCDE));
        emit(e_r(3'b000, 8, 0, 0));
        emit(32'h0);
        run_prog(20);
        rd_reg(0, v); chk("R7 x0", v, 32'h0);
        rd_reg(8, v); chk("R7 x0 as operand", v, 32'h0);

        // R6: forward taken branch and untaken branch.
        plen = 0;
        emit(e_addi(1, 0, 12'd5));
        emit(e_bne(1, 0, 8));
        emit(e_addi(9, 0, 12'd1));
        emit(e_bne(1, 1, 8));
        emit(e_addi(10, 0, 12'd2));
        emit(32'h0);
        run_prog(20);
        rd_reg(9, v);  chk("R6 taken skip", v, 32'h0);
        rd_reg(10, v); chk("R6 untaken falls through", v, 32'd2);
        chk("R6 end pc", {26'b0, pc_idx}, 32'd5);

        // R8: unsupported word halts, pc frozen, later code not run.
        plen = 0;
        emit(e_addi(11, 0, 12'd7));
        emit({7'b0100000, 5'd2, 5'd1, 3'b000, 5'd12, 7'b0110011});
        emit(e_addi(12, 0, 12'd9));
        emit(32'h0);
        run_prog(20);
        pc_hold = pc_idx;
        repeat (5) @(negedge clk);
        chk("R8 stop pc", {26'b0, pc_idx}, 32'd1);
        chk("R8 pc frozen", {26'b0, pc_idx}, {26'b0, pc_hold});
        chk("R8 halted flag", {31'b0, halted}, 32'd1);
        rd_reg(11, v); chk("R8 prior write", v, 32'd7);
        rd_reg(12, v); chk("R8 no later write", v, 32'h0);
        rd_reg(0, v);  chk("R9 debug x0", v, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule